// File: doc/BRIEF.md
# Debug Memory Access Port with Bus Arbitration

This block lets a debug controller read and write the processor's memory, its memory-mapped peripherals and a small bank of internal debug registers, all through one shared port. Commands reach it slowly, one field at a time, from an upstream message decoder. A staging register therefore collects the target address, the write data and the direction. Each field has its own load strobe, and a separate execute strobe later starts a single access from whatever the staging register holds.

Memory and peripheral accesses go out on the same bus the processor uses. When both sides want the bus in the same cycle, an arbiter normally gives it to the debug side and stalls the processor with a wait signal. A debug register bit can reverse that order. Addresses whose top nibble marks the debug register region are served inside the block, with no bus cycle. A one-cycle done pulse reports completion. On a read, the returned word is valid in the same cycle as that pulse.

Top module: `dbg_mem_port`

## Requirements
- R1: The staging register has three fields: address, write data and direction (1 = write, 0 = read). Each field loads only on its own strobe and keeps its value until that strobe loads it again.
- R2: An execute pulse while idle starts one access from the staged values. Pulsing execute again without reloading repeats the access to the same address.
- R3: While an access is in flight, execute pulses and all field load strobes are ignored. The access in flight and the next one use the values staged before it began.
- R4: By default, a debug memory request in the same cycle as a processor request wins the bus. The processor sees `cpu_wait` high in that cycle, and the bus carries the debug address.
- R5: When bit 0 of debug register 0 is 1, the processor wins every conflict, and the debug access waits until the processor stops requesting.
- R6: `cpu_wait` is high in every cycle where `cpu_req` is high and the processor does not complete a transfer, whether it lost arbitration or `bus_ready` is low.
- R7: `done` rises in the cycle after the access completes and lasts exactly one cycle. For reads, `rd_data` holds the read word from that cycle on.
- R8: An address whose top 4 bits are 0xF selects the debug registers, indexed by the low 3 bits. Such an access drives no bus cycle and completes in its first busy cycle. Indices 0 to 4 are read/write registers. Indices 5 to 7 read as zero and ignore writes.
- R9: Any other address goes to the shared bus unchanged, so memory and memory-mapped I/O are reached exactly as the processor reaches them.
- R10: After reset the port is idle, `done` and `rd_data` are zero, all debug registers are zero and the debug side has priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_addr_stb | input | 1 | Load strobe for the staged address |
| ld_addr | input | AW | Address value to stage |
| ld_data_stb | input | 1 | Load strobe for the staged write data |
| ld_data | input | DW | Write data to stage |
| ld_dir_stb | input | 1 | Load strobe for the staged direction |
| ld_dir | input | 1 | Direction to stage, 1 = write |
| go | input | 1 | Execute pulse |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Data returned by the last read |
| cpu_req | input | 1 | Processor bus request |
| cpu_we | input | 1 | Processor write enable |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Read data to the processor |
| cpu_wait | output | 1 | Processor stall |
| bus_valid | output | 1 | Shared bus request |
| bus_we | output | 1 | Shared bus write enable |
| bus_addr | output | AW | Shared bus address |
| bus_wdata | output | DW | Shared bus write data |
| bus_rdata | input | DW | Shared bus read data |
| bus_ready | input | 1 | Shared bus completes the current transfer |

## Verification
The hardest state to reach from the ports is a debug access held in flight while new staging loads and a second execute arrive. Only a stalled bus keeps the port busy long enough for that. The stimulus holds `bus_ready` low after an execute, pulses every strobe while the port is busy, and then reads back both the old and the new addresses. A second hard case is processor-priority mode with a processor that keeps requesting. The debug side reaches that mode through its own register path, then sets up the request pattern. After these directed cases, randomized processor traffic and bus stalls run alongside random debug operations, and a shadow model of memory and registers checks each one.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
   typedef enum logic {
      PS_IDLE = 1'b0,
      PS_BUSY = 1'b1
   } port_state_e;

   localparam logic DIR_WRITE = 1'b1;
   localparam logic DIR_READ  = 1'b0;
endpackage

// File: rtl/dmp_hold.sv
module dmp_hold #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lock,
   input  logic          a_stb,
   input  logic [AW-1:0] a_in,
   input  logic          d_stb,
   input  logic [DW-1:0] d_in,
   input  logic          w_stb,
   input  logic          w_in,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic          we_q
);
   // Each field has an independent strobe; all of them are frozen while locked.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         we_q    <= dmp_pkg::DIR_READ;
      end else if (!lock) begin
         if (a_stb) addr_q  <= a_in;
         if (d_stb) wdata_q <= d_in;
         if (w_stb) we_q    <= w_in;
      end
   end

   p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable({addr_q, wdata_q, we_q}))
      else $error("staged fields changed during an access");
endmodule

// File: rtl/dmp_dregs.sv
module dmp_dregs #(
   parameter int DW   = 16,
   parameter int NREG = 5,
   parameter int IW   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          cfg_bit0
);
   logic [DW-1:0] rvec [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         q <= '0;
         else if (wr_en && idx == IW'(g))    q <= wdata;
      end
      assign rvec[g] = q;
   end

   // Unimplemented indices read as zero.
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++)
         if (idx == IW'(i)) rdata = rvec[i];
   end

   assign cfg_bit0 = rvec[0][0];
endmodule

// File: rtl/dmp_arb.sv
module dmp_arb #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_first,
   input  logic          dbg_req,
   input  logic          dbg_we,
   input  logic [AW-1:0] dbg_addr,
   input  logic [DW-1:0] dbg_wdata,
   output logic          dbg_fire,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_wait,
   output logic          bus_valid,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ready
);
   logic dbg_gnt;
   logic cpu_gnt;

   assign dbg_gnt   = dbg_req & ~(cpu_first & cpu_req);
   assign cpu_gnt   = cpu_req & ~dbg_gnt;
   assign bus_valid = dbg_gnt | cpu_gnt;
   assign bus_we    = dbg_gnt ? dbg_we    : (cpu_gnt & cpu_we);
   assign bus_addr  = dbg_gnt ? dbg_addr  : cpu_addr;
   assign bus_wdata = dbg_gnt ? dbg_wdata : cpu_wdata;
   assign dbg_fire  = dbg_gnt & bus_ready;
   assign cpu_wait  = cpu_req & ~(cpu_gnt & bus_ready);
   assign cpu_rdata = bus_rdata;

   p_dbg_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && cpu_req && !cpu_first) |-> (cpu_wait && bus_addr == dbg_addr))
      else $error("debug side lost a default-priority conflict");

   p_cpu_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && cpu_req && cpu_first) |-> !dbg_fire)
      else $error("debug side fired against a prioritized processor");

   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !bus_ready) |-> cpu_wait)
      else $error("processor not stalled while bus not ready");
endmodule

// File: rtl/dbg_mem_port.sv
module dbg_mem_port #(
   parameter int          AW          = 16,
   parameter int          DW          = 16,
   parameter int          TAG_W       = 4,
   parameter logic [3:0]  DREG_TAG    = 4'hF,
   parameter int          NREG        = 5,
   parameter int          DREG_IW     = 3,
   parameter bit          PRIO_CFG_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_addr_stb,
   input  logic [AW-1:0] ld_addr,
   input  logic          ld_data_stb,
   input  logic [DW-1:0] ld_data,
   input  logic          ld_dir_stb,
   input  logic          ld_dir,
   input  logic          go,
   output logic          done,
   output logic [DW-1:0] rd_data,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   output logic          cpu_wait,
   output logic          bus_valid,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_ready
);
   import dmp_pkg::*;

   localparam int TAG_LSB = AW - TAG_W;

   if (TAG_W < 1 || TAG_W > 4 || TAG_W >= AW) begin : g_bad_tag
      $error("TAG_W must be 1..4 and narrower than AW");
   end
   if (NREG < 1 || NREG > (1 << DREG_IW)) begin : g_bad_nreg
      $error("NREG must fit in the DREG_IW index field");
   end
   if (DREG_IW >= TAG_LSB) begin : g_bad_iw
      $error("register index overlaps the region tag");
   end

   port_state_e   state;
   logic          busy;
   logic [AW-1:0] h_addr;
   logic [DW-1:0] h_wdata;
   logic          h_we;
   logic          in_dreg;
   logic          dreg_fire;
   logic          mem_fire;
   logic          finish;
   logic [DW-1:0] dreg_rdata;
   logic          cfg_bit0;
   logic          cpu_first;

   assign busy = (state == PS_BUSY);

   dmp_hold #(.AW(AW), .DW(DW)) u_hold (
      .clk(clk), .rst_n(rst_n), .lock(busy),
      .a_stb(ld_addr_stb), .a_in(ld_addr),
      .d_stb(ld_data_stb), .d_in(ld_data),
      .w_stb(ld_dir_stb),  .w_in(ld_dir),
      .addr_q(h_addr), .wdata_q(h_wdata), .we_q(h_we)
   );

   assign in_dreg   = (h_addr[AW-1:TAG_LSB] == DREG_TAG[TAG_W-1:0]);
   assign dreg_fire = busy & in_dreg;

   dmp_dregs #(.DW(DW), .NREG(NREG), .IW(DREG_IW)) u_dregs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(dreg_fire & h_we),
      .idx(h_addr[DREG_IW-1:0]),
      .wdata(h_wdata),
      .rdata(dreg_rdata),
      .cfg_bit0(cfg_bit0)
   );

   if (PRIO_CFG_EN) begin : g_prio_cfg
      assign cpu_first = cfg_bit0;
   end else begin : g_prio_fixed
      assign cpu_first = 1'b0;
   end

   dmp_arb #(.AW(AW), .DW(DW)) u_arb (
      .clk(clk), .rst_n(rst_n), .cpu_first(cpu_first),
      .dbg_req(busy & ~in_dreg), .dbg_we(h_we),
      .dbg_addr(h_addr), .dbg_wdata(h_wdata), .dbg_fire(mem_fire),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait),
      .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
   );

   assign finish = dreg_fire | mem_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= PS_IDLE;
         done    <= 1'b0;
         rd_data <= '0;
      end else begin
         done <= finish;
         if (finish) begin
            state <= PS_IDLE;
            if (h_we == DIR_READ)
               rd_data <= in_dreg ? dreg_rdata : bus_rdata;
         end else if (go && !busy) begin
            state <= PS_BUSY;
         end
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held longer than one cycle");

   p_dreg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dreg_fire && !cpu_req) |-> !bus_valid)
      else $error("register access reached the shared bus");

   p_dreg_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dreg_fire |=> (done && !busy))
      else $error("register access did not finish in one cycle");
endmodule

// File: tb/dbg_mem_port_bench.sv
module dbg_mem_port_bench;
   localparam int AW = 16;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_addr_stb = 0, ld_data_stb = 0, ld_dir_stb = 0, ld_dir = 0, go = 0;
   logic [AW-1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic          done;
   logic [DW-1:0] rd_data;
   logic          cpu_req = 0, cpu_we = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [DW-1:0] cpu_rdata;
   logic          cpu_wait;
   logic          bus_valid, bus_we;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic          bus_ready = 1'b1;

   logic [DW-1:0] mem  [16];
   logic [DW-1:0] smem [16];
   logic [DW-1:0] sreg [8];
   int            n_chk = 0;
   int            n_bad = 0;
   bit            rnd = 0;
   bit            ended = 0;

   always #2 clk = ~clk;

   dbg_mem_port u_dbg_mem_port (.*);

   function automatic logic [DW-1:0] init_word(input int i);
      return DW'(16'hC000 + i * 16'h0111);
   endfunction

   always_comb bus_rdata = mem[bus_addr[3:0]];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
      end else if (bus_valid && bus_ready && bus_we) begin
         mem[bus_addr[3:0]] <= bus_wdata;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic jitter();
      cpu_req   = ($urandom % 3) == 0;
      cpu_we    = 1'b0;
      cpu_addr  = AW'($urandom % 16);
      bus_ready = ($urandom % 4) != 0;
   endtask

   task automatic step();
      @(posedge clk); #1;
      if (rnd) jitter();
   endtask

   task automatic stage(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic w);
      step();
      ld_addr_stb = 1; ld_addr = a;
      ld_data_stb = 1; ld_data = d;
      ld_dir_stb  = 1; ld_dir  = w;
      step();
      ld_addr_stb = 0; ld_data_stb = 0; ld_dir_stb = 0;
   endtask

   task automatic pulse_go();
      go = 1;
      step();
      go = 0;
   endtask

   task automatic wait_done(input string tag, output logic [DW-1:0] rd);
      int n = 0;
      rd = '0;
      forever begin
         @(negedge clk);
         if (done) begin rd = rd_data; break; end
         n++;
         if (n > 60) begin
            check({tag, " timeout"}, 0, 1);
            break;
         end
         @(posedge clk); #1;
         if (rnd) jitter();
      end
   endtask

   task automatic dbg_op(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic w, output logic [DW-1:0] rd);
      stage(a, d, w);
      pulse_go();
      wait_done(tag, rd);
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      if (a[15:12] == 4'hF) return (a[2:0] < 5) ? sreg[a[2:0]] : '0;
      return smem[a[3:0]];
   endfunction

   task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (a[15:12] == 4'hF) begin
         if (a[2:0] < 5) sreg[a[2:0]] = d;
      end else begin
         smem[a[3:0]] = d;
      end
   endtask

   initial begin
      #(4 * 150000);
      check("watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      void'($urandom(32'h5EED));
      for (int i = 0; i < 16; i++) smem[i] = init_word(i);
      for (int i = 0; i < 8; i++) sreg[i] = '0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R10 reset state
      check("R10 done", done, 0);
      check("R10 rd_data", rd_data, 0);
      check("R10 bus_valid", bus_valid, 0);
      check("R10 cpu_wait", cpu_wait, 0);
      dbg_op("R10 reg0", 16'hF000, 0, 0, rd);
      check("R10 reg0 zero", rd, 0);

      // R7 latency and pulse width; R9 address passthrough
      stage(16'h7A5C, 16'h1357, 1);
      pulse_go();
      @(negedge clk);
      check("R9 bus_addr", bus_addr, 16'h7A5C);
      check("R9 bus_we", {bus_valid, bus_we}, 2'b11);
      check("R7 not yet done", done, 0);
      @(negedge clk);
      check("R7 done", done, 1);
      @(negedge clk);
      check("R7 done one cycle", done, 0);
      model_write(16'h7A5C, 16'h1357);
      check("R9 memory written", mem[4'hC], 16'h1357);

      stage(16'h0006, 0, 0);
      pulse_go();
      @(negedge clk);
      @(negedge clk);
      check("R7 read done", done, 1);
      check("R7 read data", rd_data, smem[6]);

      // R4 default debug priority under conflict
      cpu_req = 1; cpu_addr = 16'h0003;
      stage(16'h000B, 16'hBEEF, 1);
      pulse_go();
      @(negedge clk);
      check("R4 cpu_wait", cpu_wait, 1);
      check("R4 bus_addr", bus_addr, 16'h000B);
      @(negedge clk);
      check("R4 done", done, 1);
      check("R4 cpu resumes", {cpu_wait, bus_addr}, {1'b0, 16'h0003});
      model_write(16'h000B, 16'hBEEF);
      #1 cpu_req = 0;

      // R1 / R2: flip only the direction, re-execute without reloading address
      step();
      ld_dir_stb = 1; ld_dir = 0;
      step();
      ld_dir_stb = 0;
      pulse_go();
      wait_done("R2", rd);
      check("R1 R2 reread", rd, 16'hBEEF);
      pulse_go();
      wait_done("R2b", rd);
      check("R2 repeat", rd, 16'hBEEF);

      // R3: strobes and go ignored while stalled in flight
      bus_ready = 0;
      stage(16'h0004, 16'hAAAA, 1);
      pulse_go();
      ld_addr_stb = 1; ld_addr = 16'h0009;
      ld_data_stb = 1; ld_data = 16'h5555;
      ld_dir_stb  = 1; ld_dir  = 0;
      go = 1;
      step();
      ld_addr_stb = 0; ld_data_stb = 0; ld_dir_stb = 0; go = 0;
      step();
      bus_ready = 1;
      wait_done("R3", rd);
      model_write(16'h0004, 16'hAAAA);
      check("R3 staged write landed", mem[4], 16'hAAAA);
      check("R3 ignored addr untouched", mem[9], smem[9]);
      @(negedge clk);
      check("R3 no second access", {done, bus_valid}, 2'b00);
      pulse_go();
      @(negedge clk);
      check("R3 held addr", bus_addr, 16'h0004);
      check("R3 held dir", bus_we, 1);
      wait_done("R3b", rd);

      // R8 debug registers
      stage(16'hF003, 16'h1234, 1);
      pulse_go();
      @(negedge clk);
      check("R8 no bus cycle", bus_valid, 0);
      check("R8 fast done", done, 0);
      @(negedge clk);
      check("R8 done", done, 1);
      model_write(16'hF003, 16'h1234);
      dbg_op("R8 read", 16'hF003, 0, 0, rd);
      check("R8 reg3", rd, 16'h1234);
      dbg_op("R8 w6", 16'hF006, 16'h7777, 1, rd);
      dbg_op("R8 r6", 16'hF006, 0, 0, rd);
      check("R8 unimplemented zero", rd, 0);

      // R5 / R6 processor priority
      dbg_op("R5 set", 16'hF000, 16'h0001, 1, rd);
      model_write(16'hF000, 16'h0001);
      cpu_req = 1; cpu_addr = 16'h0007;
      stage(16'h0002, 0, 0);
      pulse_go();
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R5 cpu keeps bus", {done, cpu_wait, bus_addr}, {2'b00, 16'h0007});
      end
      #1 bus_ready = 0;
      @(negedge clk);
      check("R6 stall on not ready", cpu_wait, 1);
      #1 bus_ready = 1; cpu_req = 0;
      wait_done("R5", rd);
      check("R5 debug served after", rd, smem[2]);
      dbg_op("R5 clear", 16'hF000, 16'h0000, 1, rd);
      model_write(16'hF000, 16'h0000);

      // Randomized mix: R2 R6 R8 R9
      rnd = 1;
      for (int it = 0; it < 80; it++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] d;
         logic          w;
         if (($urandom % 10) < 7)
            a = {4'($urandom % 15), 8'($urandom), 4'($urandom)};
         else
            a = {4'hF, 9'h0, 3'(1 + $urandom % 7)};
         d = DW'($urandom);
         w = $urandom % 2;
         dbg_op("R9 random", a, d, w, rd);
         if (w) model_write(a, d);
         else   check("R8 R9 random read", rd, exp_read(a));
      end
      rnd = 0;
      cpu_req = 0; bus_ready = 1;
      for (int i = 0; i < 16; i++) begin
         dbg_op("R9 sweep", AW'(i), 0, 0, rd);
         check("R9 final memory", rd, smem[i]);
      end
      finish_run();
   end
endmodule